// File: doc/BRIEF.md
# Bus Slave Strobe/Done Handshake Controller

This block is the slave end of an asynchronous strobe-and-done bus handshake for a maintenance panel. The master raises an address-match line, chooses read or write with an active-low select, and pulls an active-low strobe. For a read, the block drives one of two stored words onto the bus data lines, waits a fixed settling interval, and answers with a timed active-low done pulse. For a write, it waits the same interval so that the data lines can settle, loads the bus word into one of two display registers, and answers with the same done pulse.

An address/data select line picks the word for both directions. When it is low, the data register is used. When it is high, the address register is used. Both registers are visible at all times on the display outputs. The block is fully synchronous. Every bus input passes through a synchronizer chain first. A new cycle needs the address match to drop and rise again. The master can abort at any point, either by releasing its strobe or by pulling quit low.

Top module: `panel_bus_slave`

## Requirements
- R1: With `slv_sel_i`=1, `rd_wr_n_i`=1 (read), `strb_n_i`=0 and `quit_n_i`=1, a read cycle starts. `bus_oe_o` goes to 1 SYNC_STAGES+1 clock cycles after these inputs are applied.
- R2: During a read with `ad_sel_i`=0, `bus_d_o` carries the data register. With `ad_sel_i`=1 it carries the address register. Whenever `bus_oe_o`=0, `bus_d_o` is all zeros.
- R3: In both read and write cycles, `done_n_o` goes low HOLD_CYC cycles after the cycle starts. It stays low for exactly DONE_CYC cycles. It is never low outside that window.
- R4: `bus_oe_o` returns to 0 in the same cycle in which the done pulse ends. It is never 1 during a write cycle or while the block is idle.
- R5: In a write cycle (`rd_wr_n_i`=0), the bus word is loaded on the clock edge that ends the hold interval. It loads into `data_disp_o` when `ad_sel_i`=0 and into `addr_disp_o` when `ad_sel_i`=1. The other register keeps its value.
- R6: After the done pulse, the block stays in its cycle until the strobe goes high. A strobe release at any earlier point ends the cycle without a done pulse and without a register load.
- R7: After a cycle, holding `slv_sel_i` high and asserting the strobe again starts no new cycle. `slv_sel_i` must first drop to 0.
- R8: `quit_n_i`=0 returns the block to idle. `bus_oe_o`=0 and `done_n_o`=1 follow one cycle after the synchronized quit, and no register is loaded.
- R9: After reset, both display registers are zero, `bus_oe_o`=0, `bus_d_o`=0 and `done_n_o`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| slv_sel_i | input | 1 | Address match from the external decoder (asynchronous) |
| rd_wr_n_i | input | 1 | 1 selects a read cycle, 0 selects a write cycle |
| strb_n_i | input | 1 | Master strobe, active low |
| ad_sel_i | input | 1 | 0 selects the data word, 1 selects the address word |
| quit_n_i | input | 1 | Master abort, active low |
| bus_d_i | input | W | Bus data lines, inbound |
| bus_d_o | output | W | Bus data lines, outbound |
| bus_oe_o | output | 1 | Tri-state enable for `bus_d_o` |
| done_n_o | output | 1 | Done pulse to the master, active low |
| data_disp_o | output | W | Data display register |
| addr_disp_o | output | W | Address display register |

## Verification
The bench builds the block with W=8, HOLD_CYC=20, DONE_CYC=10 and SYNC_STAGES=2. With the 200 MHz bench clock, these counts keep the 100 ns hold and the 50 ns done pulse. The 8-bit width still lets distinct patterns show which register was read or loaded. A behavioural model tracks cycle age through the synchronizer delay and predicts the outputs on every clock. It covers both read selections, both write targets, the exact pulse placement and width, strobe release during a cycle, quit during a read and during a write, and the rule that the address match must drop before a new cycle.

// File: rtl/panel_hs_pkg.sv
package panel_hs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_RD_WAIT   = 3'd1,
    ST_WR_WAIT   = 3'd2,
    ST_DONE      = 3'd3,
    ST_WAIT_HIGH = 3'd4
  } hs_state_t;
endpackage

// File: rtl/panel_hs_sync.sv
module panel_hs_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg_q[0] <= RST_VAL;
    else     stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg_q[s] <= RST_VAL;
      else     stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/panel_hs_ctrl.sv
module panel_hs_ctrl
  import panel_hs_pkg::*;
#(
  parameter int HOLD_CYC = 10,
  parameter int DONE_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic rd_i,
  input  logic strb_n_i,
  input  logic ad_i,
  input  logic quit_n_i,
  output logic drive_nxt_o,
  output logic pick_addr_nxt_o,
  output logic wr_data_o,
  output logic wr_addr_o,
  output logic oe_o,
  output logic done_n_o
);
  localparam int MAXC = (HOLD_CYC > DONE_CYC) ? HOLD_CYC : DONE_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] DONE_LD = CW'(DONE_CYC - 1);

  hs_state_t state_q, state_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic rd_q, ad_q, armed_q, oe_q, done_n_q;
  logic start, abort, wr_fire, rd_nxt, ad_nxt;

  assign start = (state_q == ST_IDLE) && armed_q && sel_i && !strb_n_i && quit_n_i;
  assign abort = (state_q != ST_IDLE) && (!quit_n_i || strb_n_i);
  assign rd_nxt = start ? rd_i : rd_q;
  assign ad_nxt = start ? ad_i : ad_q;

  always_comb begin
    state_nxt = state_q;
    cnt_nxt   = cnt_q;
    wr_fire   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_nxt = rd_i ? ST_RD_WAIT : ST_WR_WAIT;
          cnt_nxt   = HOLD_LD;
        end
      end
      ST_RD_WAIT, ST_WR_WAIT: begin
        if (cnt_q == '0) begin
          state_nxt = ST_DONE;
          cnt_nxt   = DONE_LD;
          wr_fire   = (state_q == ST_WR_WAIT);
        end else begin
          cnt_nxt = cnt_q - 1'b1;
        end
      end
      ST_DONE: begin
        if (cnt_q == '0) state_nxt = ST_WAIT_HIGH;
        else             cnt_nxt = cnt_q - 1'b1;
      end
      ST_WAIT_HIGH: state_nxt = ST_WAIT_HIGH;
      default: state_nxt = ST_IDLE;
    endcase
    if (abort) begin
      state_nxt = ST_IDLE;
      wr_fire   = 1'b0;
    end
  end

  assign drive_nxt_o = rd_nxt && ((state_nxt == ST_RD_WAIT) || (state_nxt == ST_DONE));
  assign pick_addr_nxt_o = ad_nxt;
  assign wr_data_o = wr_fire && !ad_q;
  assign wr_addr_o = wr_fire && ad_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      rd_q     <= 1'b0;
      ad_q     <= 1'b0;
      armed_q  <= 1'b1;
      oe_q     <= 1'b0;
      done_n_q <= 1'b1;
    end else begin
      state_q  <= state_nxt;
      cnt_q    <= cnt_nxt;
      rd_q     <= rd_nxt;
      ad_q     <= ad_nxt;
      oe_q     <= drive_nxt_o;
      done_n_q <= (state_nxt != ST_DONE);
      if (start)       armed_q <= 1'b0;
      else if (!sel_i) armed_q <= 1'b1;
    end
  end

  assign oe_o = oe_q;
  assign done_n_o = done_n_q;

  AST_DONE_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
    !done_n_q |-> (state_q == ST_DONE)) else $error("done outside pulse state"); // R3
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> (rd_q && ((state_q == ST_RD_WAIT) || (state_q == ST_DONE)))) else $error("oe outside read"); // R4
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_data_o, wr_addr_o})) else $error("two load targets"); // R5
  AST_HOLD_TILL_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_HIGH && !strb_n_i && quit_n_i) |=> (state_q == ST_WAIT_HIGH)) else $error("left early"); // R6
  AST_NO_REARM: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !armed_q) |=> (state_q == ST_IDLE)) else $error("restart without rearm"); // R7
  AST_QUIT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !quit_n_i |=> (state_q == ST_IDLE && !oe_q && done_n_q)) else $error("quit not honoured"); // R8
endmodule

// File: rtl/panel_hs_regs.sv
module panel_hs_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  input  logic         wr_data_i,
  input  logic         wr_addr_i,
  input  logic         drive_nxt_i,
  input  logic         pick_addr_nxt_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] addr_o,
  output logic [W-1:0] bus_o
);
  logic [W-1:0] data_q, addr_q, bus_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      addr_q <= '0;
      bus_q  <= '0;
    end else begin
      if (wr_data_i) data_q <= d_i;
      if (wr_addr_i) addr_q <= d_i;
      bus_q <= drive_nxt_i ? (pick_addr_nxt_i ? addr_q : data_q) : '0;
    end
  end

  assign data_o = data_q;
  assign addr_o = addr_q;
  assign bus_o  = bus_q;

  AST_LOAD_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!wr_data_i && !wr_addr_i) |=> ($stable(data_q) && $stable(addr_q))) else $error("unexpected load"); // R5
endmodule

// File: rtl/panel_bus_slave.sv
module panel_bus_slave #(
  parameter int W = 16,
  parameter int HOLD_CYC = 10,
  parameter int DONE_CYC = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         slv_sel_i,
  input  logic         rd_wr_n_i,
  input  logic         strb_n_i,
  input  logic         ad_sel_i,
  input  logic         quit_n_i,
  input  logic [W-1:0] bus_d_i,
  output logic [W-1:0] bus_d_o,
  output logic         bus_oe_o,
  output logic         done_n_o,
  output logic [W-1:0] data_disp_o,
  output logic [W-1:0] addr_disp_o
);
  localparam int NCTL = 5;
  localparam logic [NCTL-1:0] CTL_RST = 5'b01101;

  logic [NCTL-1:0] ctl_s;
  logic [W-1:0] bus_s;
  logic drive_nxt, pick_addr_nxt, wr_data, wr_addr;

  panel_hs_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_ctl_sync (
    .clk(clk), .rst(rst),
    .d_i({slv_sel_i, rd_wr_n_i, strb_n_i, ad_sel_i, quit_n_i}),
    .q_o(ctl_s)
  );

  panel_hs_sync #(.W(W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
    .clk(clk), .rst(rst), .d_i(bus_d_i), .q_o(bus_s)
  );

  panel_hs_ctrl #(.HOLD_CYC(HOLD_CYC), .DONE_CYC(DONE_CYC)) u_ctrl (
    .clk(clk), .rst(rst),
    .sel_i(ctl_s[4]), .rd_i(ctl_s[3]), .strb_n_i(ctl_s[2]),
    .ad_i(ctl_s[1]), .quit_n_i(ctl_s[0]),
    .drive_nxt_o(drive_nxt), .pick_addr_nxt_o(pick_addr_nxt),
    .wr_data_o(wr_data), .wr_addr_o(wr_addr),
    .oe_o(bus_oe_o), .done_n_o(done_n_o)
  );

  panel_hs_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .d_i(bus_s),
    .wr_data_i(wr_data), .wr_addr_i(wr_addr),
    .drive_nxt_i(drive_nxt), .pick_addr_nxt_i(pick_addr_nxt),
    .data_o(data_disp_o), .addr_o(addr_disp_o), .bus_o(bus_d_o)
  );
endmodule

// File: tb/tb_panel_bus_slave.sv
`timescale 1ns/1ps
module tb_panel_bus_slave;
  localparam int W = 8;
  localparam int HOLD = 20;
  localparam int DONE = 10;
  localparam int SYN = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic sel = 1'b0, rw = 1'b1, strb_n = 1'b1, ad = 1'b0, quit_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] bus_d_o, data_disp_o, addr_disp_o;
  logic bus_oe_o, done_n_o;

  int nchk = 0, nbad = 0;

  panel_bus_slave #(.W(W), .HOLD_CYC(HOLD), .DONE_CYC(DONE), .SYNC_STAGES(SYN)) dut (
    .clk(clk), .rst(rst), .slv_sel_i(sel), .rd_wr_n_i(rw), .strb_n_i(strb_n),
    .ad_sel_i(ad), .quit_n_i(quit_n), .bus_d_i(din), .bus_d_o(bus_d_o),
    .bus_oe_o(bus_oe_o), .done_n_o(done_n_o),
    .data_disp_o(data_disp_o), .addr_disp_o(addr_disp_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Reference model: synchronizer delay queues plus cycle age
  logic p_sel[$], p_rw[$], p_strb[$], p_ad[$], p_quit[$];
  logic [W-1:0] p_d[$];
  bit m_act, m_rd, m_ad, m_arm;
  int m_t;
  logic [W-1:0] m_data, m_addr;

  task automatic model_reset();
    p_sel = {}; p_rw = {}; p_strb = {}; p_ad = {}; p_quit = {}; p_d = {};
    for (int i = 0; i < SYN; i++) begin
      p_sel.push_back(1'b0); p_rw.push_back(1'b1); p_strb.push_back(1'b1);
      p_ad.push_back(1'b0); p_quit.push_back(1'b1); p_d.push_back('0);
    end
    m_act = 0; m_rd = 0; m_ad = 0; m_arm = 1; m_t = 0; m_data = '0; m_addr = '0;
  endtask

  always @(posedge clk) begin
    if (rst) model_reset();
    else begin
      logic s_sel, s_rw, s_strb, s_ad, s_quit;
      logic [W-1:0] s_d;
      bit started;
      s_sel = p_sel[0]; s_rw = p_rw[0]; s_strb = p_strb[0];
      s_ad = p_ad[0]; s_quit = p_quit[0]; s_d = p_d[0];
      started = 0;
      if (m_act) begin
        if (!s_quit || s_strb) m_act = 0;
        else begin
          if (!m_rd && m_t == HOLD - 1) begin
            if (m_ad) m_addr = s_d; else m_data = s_d;
          end
          m_t++;
        end
      end else if (m_arm && s_sel && !s_strb && s_quit) begin
        m_act = 1; m_t = 0; m_rd = s_rw; m_ad = s_ad; started = 1;
      end
      if (started) m_arm = 0;
      else if (!s_sel) m_arm = 1;
      void'(p_sel.pop_front()); p_sel.push_back(sel);
      void'(p_rw.pop_front()); p_rw.push_back(rw);
      void'(p_strb.pop_front()); p_strb.push_back(strb_n);
      void'(p_ad.pop_front()); p_ad.push_back(ad);
      void'(p_quit.pop_front()); p_quit.push_back(quit_n);
      void'(p_d.pop_front()); p_d.push_back(din);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      logic e_oe, e_dn;
      logic [W-1:0] e_bus;
      e_oe = m_act && m_rd && (m_t < HOLD + DONE);
      e_dn = !(m_act && m_t >= HOLD && m_t < HOLD + DONE);
      e_bus = e_oe ? (m_ad ? m_addr : m_data) : '0;
      chk("R4", "bus_oe_o model", 32'(bus_oe_o), 32'(e_oe));
      chk("R3", "done_n_o model", 32'(done_n_o), 32'(e_dn));
      chk("R2", "bus_d_o model", 32'(bus_d_o), 32'(e_bus));
      chk("R5", "data_disp_o model", 32'(data_disp_o), 32'(m_data));
      chk("R5", "addr_disp_o model", 32'(addr_disp_o), 32'(m_addr));
    end
  end

  task automatic release_all();
    @(negedge clk);
    strb_n = 1'b1; sel = 1'b0; quit_n = 1'b1;
    repeat (SYN + 3) @(negedge clk);
  endtask

  task automatic begin_cycle(input logic r, input logic a, input logic [W-1:0] d);
    @(negedge clk);
    sel = 1'b1; rw = r; ad = a; din = d; strb_n = 1'b0;
  endtask

  task automatic full_cycle(input logic r, input logic a, input logic [W-1:0] d, input logic [W-1:0] exp_bus);
    int lat, wid;
    begin_cycle(r, a, d);
    lat = 0;
    do begin
      @(negedge clk); lat++;
      if (lat == SYN + 1) begin
        chk("R1", "oe at start", 32'(bus_oe_o), 32'(r));
        if (r) chk("R2", "read word", 32'(bus_d_o), 32'(exp_bus));
      end
    end while (done_n_o && lat < 500);
    chk("R3", "done latency", lat, HOLD + SYN + 1);
    wid = 0;
    while (!done_n_o && wid < 500) begin @(negedge clk); wid++; end
    chk("R3", "done width", wid, DONE);
    chk("R4", "oe drops with done", 32'(bus_oe_o), 0);
    repeat (4) @(negedge clk);
    chk("R6", "holds with strobe low", 32'(done_n_o), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "reset oe", 32'(bus_oe_o), 0);
    chk("R9", "reset done", 32'(done_n_o), 1);
    chk("R9", "reset data", 32'(data_disp_o), 0);
    chk("R9", "reset addr", 32'(addr_disp_o), 0);
    chk("R9", "reset bus", 32'(bus_d_o), 0);

    full_cycle(1'b0, 1'b0, 8'hA5, '0); release_all();
    chk("R5", "data loaded", 32'(data_disp_o), 32'hA5);
    chk("R5", "addr untouched", 32'(addr_disp_o), 0);
    full_cycle(1'b0, 1'b1, 8'h3C, '0); release_all();
    chk("R5", "addr loaded", 32'(addr_disp_o), 32'h3C);
    chk("R5", "data untouched", 32'(data_disp_o), 32'hA5);
    full_cycle(1'b1, 1'b0, 8'h00, 8'hA5); release_all();
    full_cycle(1'b1, 1'b1, 8'hFF, 8'h3C); release_all();
    chk("R2", "read leaves regs", 32'(addr_disp_o), 32'h3C);

    // R7: strobe again with match still high
    full_cycle(1'b0, 1'b0, 8'h5A, '0);
    @(negedge clk); strb_n = 1'b1;
    repeat (SYN + 2) @(negedge clk);
    strb_n = 1'b0; din = 8'h99;
    begin
      int lows = 0;
      for (int i = 0; i < HOLD + DONE + SYN + 6; i++) begin
        @(negedge clk);
        if (!done_n_o || bus_oe_o) lows++;
      end
      chk("R7", "no restart without match drop", lows, 0);
    end
    chk("R7", "no reload", 32'(data_disp_o), 32'h5A);
    release_all();

    // R8: quit during a read
    begin_cycle(1'b1, 1'b1, 8'h00);
    repeat (8) @(negedge clk);
    quit_n = 1'b0;
    repeat (SYN + 1) @(negedge clk);
    chk("R8", "quit oe", 32'(bus_oe_o), 0);
    chk("R8", "quit done", 32'(done_n_o), 1);
    chk("R8", "quit bus", 32'(bus_d_o), 0);
    release_all();

    // R8: quit during a write
    begin_cycle(1'b0, 1'b0, 8'h11);
    repeat (8) @(negedge clk);
    quit_n = 1'b0;
    repeat (HOLD + DONE) @(negedge clk);
    chk("R8", "quit write no load", 32'(data_disp_o), 32'h5A);
    release_all();

    // R6: early strobe release during a write
    begin_cycle(1'b0, 1'b1, 8'h77);
    repeat (6) @(negedge clk);
    strb_n = 1'b1;
    begin
      int lows = 0;
      for (int i = 0; i < HOLD + DONE; i++) begin
        @(negedge clk);
        if (!done_n_o) lows++;
      end
      chk("R6", "early release no done", lows, 0);
    end
    chk("R6", "early release no load", 32'(addr_disp_o), 32'h3C);
    release_all();

    // normal cycle after aborts
    full_cycle(1'b1, 1'b0, 8'h00, 8'h5A); release_all();

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog R1 act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule